// File: doc/BRIEF.md
# Dual-Source ADC Result Register Bank

This block keeps the 10-bit results of an analog-to-digital converter in two 16-bit read-only registers. The trigger source of each completed conversion decides where its result goes. Conversions started by software go to the software result register. Conversions started by an internal hardware event or by the external trigger pin go to the hardware result register. Each result is stored left-justified, and the six lowest register bits are always zero.

A CPU reads the bank over an 8-bit bus with no wait states. Reading a register's upper byte returns that byte directly. In the same cycle, the register's current lower byte is copied into a single temporary latch that both registers share. The lower-byte address always returns the latch contents. A 16-bit value read upper byte first is therefore coherent, even when a new completion lands between the two byte reads. Reset clears both registers and the latch, and so does any of the five low-power mode indications.

Top module: `adc_result_bank`

## Requirements
- R1: A captured result d[9:0] appears as d[9:2] at the upper byte and d[1:0] in bits 7..6 of the lower byte.
- R2: Bits 5..0 of both registers, and therefore of every lower-byte read, are always zero.
- R3: A completion with the source flag low (software) updates only the software register.
- R4: A completion with the source flag high (hardware or external trigger) updates only the hardware register.
- R5: Without a completion, both registers keep their values.
- R6: Bus writes (`wr` with any `wdata` and address) change no register and no latch content.
- R7: Synchronous active-low reset clears both registers and the latch to zero.
- R8: While any bit of `lp_mode` is high, both registers and the latch clear to zero and completions are not captured.
- R9: Address map: 0 = software upper byte, 1 = software lower byte, 2 = hardware upper byte, 3 = hardware lower byte. An upper-byte read loads that register's lower byte into the shared latch. Lower-byte addresses return the latch, never the live register.
- R10: A completion in the same cycle as an upper-byte read of the same register is captured. The read returns the old upper byte, and the latch receives the old lower byte.
- R11: `rdata` is combinational from `cs`, `rd`, `addr` and the stored state, and it is zero whenever `cs` and `rd` are not both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lp_mode | input | 5 | Low-power mode indications (module stop, standby, watch, subactive, subsleep); any high bit clears |
| conv_done | input | 1 | One-cycle completion pulse from the converter |
| conv_src_hw | input | 1 | Source of the completing conversion: 0 software, 1 hardware/external |
| conv_data | input | 10 | Conversion result, valid with `conv_done` |
| cs | input | 1 | Chip select |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe (ignored) |
| addr | input | 2 | Byte address; bit 1 selects the register, bit 0 selects the lower byte |
| wdata | input | 8 | Write data (ignored) |
| rdata | output | 8 | Read data, zero-wait combinational |

## Verification
The checker assumes that `conv_done` and `conv_data` are sampled on the clock edge, that `conv_src_hw` is meaningful only while `conv_done` is high, and that the bus strobes are synchronous to the same clock. The checker makes no assumption about how completions and reads overlap. The bench changes every input only on the falling edge. It issues completions as single-cycle pulses. It places completions deliberately on the same cycle as upper-byte reads, during low-power clears and next to write attempts, so that the capture and latch ordering rules are exercised at their boundaries.

// File: rtl/adc_bank_pkg.sv
// Package: shared widths and the trigger-source encoding for the result bank.
// Assumes a result no wider than the register, and a register exactly two bus bytes wide.
package adc_bank_pkg;
    localparam int RES_W   = 10;
    localparam int REG_W   = 16;
    localparam int BUS_W   = 8;
    localparam int CLR_W   = 5;
    localparam int NUM_SRC = 2;

    typedef enum logic {
        SRC_SW = 1'b0,
        SRC_HW = 1'b1
    } trig_src_e;
endpackage

// File: rtl/adc_result_reg.sv
// Module: one left-justified result register that accepts completions of one trigger class.
// Assumes done is a single-cycle pulse and that clr takes priority over capture.
module adc_result_reg #(
    parameter int   RES_W  = 10,
    parameter int   REG_W  = 16,
    parameter logic MY_SRC = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             done,
    input  logic             src,
    input  logic [RES_W-1:0] data,
    output logic [REG_W-1:0] q
);
    localparam int PAD_W = REG_W - RES_W;

    // Capture a matching completion, clear on reset or low-power.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (clr) begin
            q <= '0;
        end else if (done && (src == MY_SRC)) begin
            q <= {data, {PAD_W{1'b0}}};
        end
    end
endmodule

// File: rtl/adc_byte_latch.sv
// Module: shared temporary byte latch that holds a lower byte for a coherent second read.
// Assumes load is asserted only for upper-byte reads.
module adc_byte_latch #(
    parameter int BUS_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             load,
    input  logic [BUS_W-1:0] din,
    output logic [BUS_W-1:0] q
);
    // Hold the lower byte sampled at the last upper-byte read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (clr) begin
            q <= '0;
        end else if (load) begin
            q <= din;
        end
    end
endmodule

// File: rtl/adc_read_mux.sv
// Module: zero-wait read multiplexer for the byte bus.
// Assumes addr[1] selects the register and addr[0] selects the lower byte (from the latch).
module adc_read_mux #(
    parameter int BUS_W = 8
) (
    input  logic             cs,
    input  logic             rd,
    input  logic [1:0]       addr,
    input  logic [BUS_W-1:0] sw_hi,
    input  logic [BUS_W-1:0] hw_hi,
    input  logic [BUS_W-1:0] tmp,
    output logic [BUS_W-1:0] rdata
);
    // Pick the byte for the current bus read, zero when idle.
    always_comb begin
        rdata = '0;
        if (cs && rd) begin
            if (addr[0]) begin
                rdata = tmp;
            end else if (addr[1]) begin
                rdata = hw_hi;
            end else begin
                rdata = sw_hi;
            end
        end
    end
endmodule

// File: rtl/adc_result_bank.sv
// Module: two read-only ADC result registers steered by trigger source, read over a byte bus.
// Assumes a 16-bit register (two bus bytes), synchronous bus strobes and one-cycle completions.
// Writes are accepted on the bus but have no effect.
module adc_result_bank #(
    parameter int RES_W = adc_bank_pkg::RES_W,
    parameter int REG_W = adc_bank_pkg::REG_W,
    parameter int BUS_W = adc_bank_pkg::BUS_W,
    parameter int CLR_W = adc_bank_pkg::CLR_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CLR_W-1:0] lp_mode,
    input  logic             conv_done,
    input  logic             conv_src_hw,
    input  logic [RES_W-1:0] conv_data,
    input  logic             cs,
    input  logic             rd,
    input  logic             wr,
    input  logic [1:0]       addr,
    input  logic [BUS_W-1:0] wdata,
    output logic [BUS_W-1:0] rdata
);
    import adc_bank_pkg::*;

    logic             clr_any;
    logic [REG_W-1:0] reg_q [NUM_SRC];
    logic [REG_W-1:0] sw_q;
    logic [REG_W-1:0] hw_q;
    logic [BUS_W-1:0] tmp_q;
    logic             tmp_load;
    logic [BUS_W-1:0] tmp_din;
    logic             unused_wr_sink;

    assign clr_any        = |lp_mode;
    assign unused_wr_sink = ^{wr, wdata};

    // One result register per trigger class.
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_reg
        adc_result_reg #(
            .RES_W (RES_W),
            .REG_W (REG_W),
            .MY_SRC(g[0])
        ) u_reg (
            .clk  (clk),
            .rst_n(rst_n),
            .clr  (clr_any),
            .done (conv_done),
            .src  (conv_src_hw),
            .data (conv_data),
            .q    (reg_q[g])
        );
    end

    assign sw_q = reg_q[SRC_SW];
    assign hw_q = reg_q[SRC_HW];

    assign tmp_load = cs && rd && !addr[0];
    assign tmp_din  = addr[1] ? hw_q[BUS_W-1:0] : sw_q[BUS_W-1:0];

    adc_byte_latch #(.BUS_W(BUS_W)) u_latch (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (clr_any),
        .load (tmp_load),
        .din  (tmp_din),
        .q    (tmp_q)
    );

    adc_read_mux #(.BUS_W(BUS_W)) u_mux (
        .cs   (cs),
        .rd   (rd),
        .addr (addr),
        .sw_hi(sw_q[REG_W-1 -: BUS_W]),
        .hw_hi(hw_q[REG_W-1 -: BUS_W]),
        .tmp  (tmp_q),
        .rdata(rdata)
    );
endmodule

// File: rtl/adc_result_bank_chk.sv
// Module: property checker for the result bank, bound to every instance of the top.
// Assumes synchronous inputs sampled on the rising edge.
module adc_result_bank_chk #(
    parameter int RES_W = 10,
    parameter int REG_W = 16,
    parameter int BUS_W = 8,
    parameter int CLR_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CLR_W-1:0] lp_mode,
    input logic             conv_done,
    input logic             conv_src_hw,
    input logic [RES_W-1:0] conv_data,
    input logic             cs,
    input logic             rd,
    input logic [1:0]       addr,
    input logic [BUS_W-1:0] rdata,
    input logic [REG_W-1:0] sw_q,
    input logic [REG_W-1:0] hw_q,
    input logic [BUS_W-1:0] tmp_q
);
    localparam int PAD_W = REG_W - RES_W;

    // R2
    pad_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sw_q[PAD_W-1:0] == '0 && hw_q[PAD_W-1:0] == '0);

    // R3
    sw_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done && !conv_src_hw && lp_mode == '0) |=>
        (sw_q == {$past(conv_data), {PAD_W{1'b0}}} && $stable(hw_q)));

    // R4
    hw_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done && conv_src_hw && lp_mode == '0) |=>
        (hw_q == {$past(conv_data), {PAD_W{1'b0}}} && $stable(sw_q)));

    // R5
    hold_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!conv_done && lp_mode == '0) |=> ($stable(sw_q) && $stable(hw_q)));

    // R8
    lowpower_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lp_mode != '0) |=> (sw_q == '0 && hw_q == '0 && tmp_q == '0));

    // R9
    latch_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && rd && !addr[0] && lp_mode == '0) |=>
        (tmp_q == $past(addr[1] ? hw_q[BUS_W-1:0] : sw_q[BUS_W-1:0])));

    // R11
    idle_bus_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cs && rd) |-> rdata == '0);
endmodule

bind adc_result_bank adc_result_bank_chk #(
    .RES_W(RES_W), .REG_W(REG_W), .BUS_W(BUS_W), .CLR_W(CLR_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .lp_mode    (lp_mode),
    .conv_done  (conv_done),
    .conv_src_hw(conv_src_hw),
    .conv_data  (conv_data),
    .cs         (cs),
    .rd         (rd),
    .addr       (addr),
    .rdata      (rdata),
    .sw_q       (sw_q),
    .hw_q       (hw_q),
    .tmp_q      (tmp_q)
);

// File: tb/sim_adc_result_bank.sv
// Bench: behavioural reference model compared against rdata on every clock.
module sim_adc_result_bank;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] lp_mode = '0;
    logic       conv_done = 1'b0;
    logic       conv_src_hw = 1'b0;
    logic [9:0] conv_data = '0;
    logic       cs = 1'b0;
    logic       rd = 1'b0;
    logic       wr = 1'b0;
    logic [1:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;

    int n_run  = 0;
    int n_fail = 0;
    int m_sw   = 0;
    int m_hw   = 0;
    int m_tmp  = 0;
    bit done_flag = 0;

    always #2 clk = ~clk;

    adc_result_bank u0 (
        .clk(clk), .rst_n(rst_n), .lp_mode(lp_mode),
        .conv_done(conv_done), .conv_src_hw(conv_src_hw), .conv_data(conv_data),
        .cs(cs), .rd(rd), .wr(wr), .addr(addr), .wdata(wdata), .rdata(rdata)
    );

    // Compare rdata with the model this cycle, then advance the model at the edge.
    task automatic tick(input string tag);
        int exp;
        #1;
        exp = 0;
        if (cs && rd) begin
            case (addr)
                2'd0: exp = (m_sw >> 8) & 255;
                2'd2: exp = (m_hw >> 8) & 255;
                default: exp = m_tmp;
            endcase
        end
        n_run++;
        if (rdata !== exp[7:0]) begin
            n_fail++;
            $display("FAIL %s: rdata=%h expected %h", tag, rdata, exp[7:0]);
        end
        @(posedge clk);
        if (!rst_n || lp_mode != 0) begin
            m_sw = 0; m_hw = 0; m_tmp = 0;
        end else begin
            if (cs && rd && !addr[0]) m_tmp = (addr[1] ? m_hw : m_sw) & 255;
            if (conv_done) begin
                if (conv_src_hw) m_hw = int'(conv_data) << 6;
                else             m_sw = int'(conv_data) << 6;
            end
        end
        @(negedge clk);
        conv_done = 0; cs = 0; rd = 0; wr = 0; wdata = 0; addr = 0;
    endtask

    task automatic rd_byte(input string tag, input logic [1:0] a);
        cs = 1; rd = 1; addr = a;
        tick(tag);
    endtask

    task automatic complete(input string tag, input logic hw, input logic [9:0] d);
        conv_done = 1; conv_src_hw = hw; conv_data = d;
        tick(tag);
    endtask

    task automatic read_all(input string tag);
        rd_byte(tag, 2'd0); rd_byte(tag, 2'd1);
        rd_byte(tag, 2'd2); rd_byte(tag, 2'd3);
    endtask

    initial begin
        @(negedge clk);
        tick("R7"); tick("R7");
        rst_n = 1;
        read_all("R7");

        // R1 R2 R3: software capture, left-justified
        complete("R3", 1'b0, 10'h2A5);
        read_all("R1");
        read_all("R2");
        // R4: hardware capture leaves software register alone
        complete("R4", 1'b1, 10'h3FF);
        read_all("R4");
        complete("R4", 1'b1, 10'h001);
        read_all("R4");
        // R5: idle hold
        tick("R5"); tick("R5"); tick("R5");
        read_all("R5");
        // R6: writes ignored at every address
        for (int a = 0; a < 4; a++) begin
            cs = 1; wr = 1; addr = 2'(a); wdata = 8'hFF;
            tick("R6");
        end
        read_all("R6");
        // R9: lower reads come from the latch, not the live register
        rd_byte("R9", 2'd2);
        complete("R9", 1'b0, 10'h155);
        rd_byte("R9", 2'd3);
        rd_byte("R9", 2'd1);
        rd_byte("R9", 2'd0);
        rd_byte("R9", 2'd1);
        // R10: completion during an upper-byte read of the same register
        cs = 1; rd = 1; addr = 2'd0;
        conv_done = 1; conv_src_hw = 0; conv_data = 10'h0EA;
        tick("R10");
        rd_byte("R10", 2'd1);
        rd_byte("R10", 2'd0);
        rd_byte("R10", 2'd1);
        cs = 1; rd = 1; addr = 2'd2;
        conv_done = 1; conv_src_hw = 1; conv_data = 10'h2C3;
        tick("R10");
        rd_byte("R10", 2'd3);
        read_all("R10");
        // R11: no output without both cs and rd
        rd = 1; addr = 2'd0; tick("R11");
        cs = 1; addr = 2'd2; tick("R11");
        // R8: each low-power indication clears, and blocks capture
        for (int b = 0; b < 5; b++) begin
            complete("R8", 1'b0, 10'(b * 97 + 3));
            complete("R8", 1'b1, 10'(b * 61 + 7));
            rd_byte("R8", 2'd0);
            lp_mode = 5'(1 << b);
            conv_done = 1; conv_src_hw = b[0]; conv_data = 10'h3AA;
            tick("R8");
            lp_mode = 0;
            read_all("R8");
        end
        // R7: reset in the middle of operation
        complete("R7", 1'b0, 10'h321);
        complete("R7", 1'b1, 10'h123);
        rd_byte("R7", 2'd2);
        rst_n = 0; tick("R7");
        rst_n = 1;
        read_all("R7");
        done_flag = 1;
    end

    // Report the summary once the sequence finishes or the watchdog expires.
    initial begin
        fork
            wait (done_flag);
            begin
                #800000;
                n_fail++;
                $display("FAIL watchdog: run did not finish, expected completion");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule